// File: doc/BRIEF.md
# Free-Running Binary Counter with Low-Phase Decode Strobes

This block is a small synchronous binary counter that runs continuously from start-up. Three particular count values are watched, and each one drives its own strobe output. A strobe does not stay high for the whole cycle. It is combined with the inverted clock, so it rises only during the low half of the cycle in which the counter holds the matching value. The result is a clean half-cycle pulse that starts after the counter bits have settled on the rising edge. Logic downstream can use these pulses as timing events for its own work.

Each counter stage is a toggle cell. A stage flips when every stage below it holds 1, and the lowest stage flips on every clock. One active-low reset clears all stages together on a rising edge, and it also holds every strobe low while it is asserted. The counter bits are brought out so that the sequence can be observed.

Top module: `phase_strobe_counter`

## Requirements
- R1: While rst_n is high, each rising clk edge raises count_o by exactly one in standard binary.
- R2: From the all-ones value (7 for the default 3-bit width), the next rising edge with rst_n high returns count_o to 0.
- R3: strobe_o[0] decodes count 2, strobe_o[1] decodes count 3 and strobe_o[2] decodes count 5. At most one strobe bit is high at any time.
- R4: A strobe bit is high only while clk is low, during the low phase that follows the rising edge that loaded its count. In the high phase, all strobe bits are 0.
- R5: A rising clk edge with rst_n low sets count_o to 0. All strobe bits stay 0 while rst_n is low, whatever the clock phase.
- R6: Bit 0 of count_o changes on every counting edge. Bit i (i>0) changes on a counting edge exactly when all bits below it were 1 before that edge.
- R7: While count_o holds any value other than 2, 3 or 5 (that is 0, 1, 4, 6 or 7), all strobe bits are 0 in both clock phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock; its low phase also gates the strobes |
| rst_n | input | 1 | Synchronous active-low clear of all stages; also forces the strobes low |
| strobe_o | output | 3 | Half-cycle decode pulses: bit 0 for count 2, bit 1 for count 3, bit 2 for count 5 |
| count_o | output | 3 | Present counter value, for observation |

## Verification
The bench builds the block with its default parameters: a 3-bit counter and the decode set 2, 3 and 5. With these values the whole 8-state cycle repeats every eight clocks, so a few thousand cycles cover every state, every wrap and every strobe many times over. Resets are inserted at random points, so the clear is tested from every count value. Sampling once in each clock phase confirms that each strobe fills only the low half of its cycle.

// File: rtl/pscnt_pkg.sv
// Package: shared defaults for the low-phase strobe counter.
// Assumes: decode values are distinct and fit in the counter width.
package pscnt_pkg;
    localparam int unsigned DEF_CNT_W = 3;
    localparam int unsigned DEF_N_STB = 3;
    // Packed decode values; entry k sits at bits [k*W +: W].
    localparam logic [DEF_N_STB*DEF_CNT_W-1:0] DEF_MATCH = {3'd5, 3'd3, 3'd2};
endpackage

// File: rtl/tff_stage.sv
// Module: tff_stage
// One toggle cell of the counter. It flips its state on a rising edge when
// tog_i is 1 and clears on a rising edge when rst_n is low.
// Assumes: tog_i is settled before the rising edge.
module tff_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_i,
    output logic q_o
);
    // Purpose: hold or flip the stage state; synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= 1'b0;
        else if (tog_i)  q_o <= ~q_o;
    end

    // R6: an enabled stage flips and a disabled stage holds.
    assert_stage_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tog_i |=> (q_o != $past(q_o)));
    assert_stage_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tog_i |=> (q_o == $past(q_o)));
endmodule

// File: rtl/toggle_counter.sv
// Module: toggle_counter
// Synchronous binary up-counter built from toggle cells. Each cell flips when
// all lower cells hold 1, and every cell shares one clock and one clear.
// Assumes: CNT_W >= 1.
module toggle_counter #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] tog;

    // Purpose: the lowest stage always toggles.
    assign tog[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < CNT_W; gi++) begin : g_stage
            if (gi > 0) begin : g_chain
                // Purpose: carry chain, a stage toggles when every lower bit is 1.
                assign tog[gi] = tog[gi-1] & cnt_o[gi-1];
            end
            tff_stage u_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .tog_i (tog[gi]),
                .q_o   (cnt_o[gi])
            );
        end
    endgenerate

    // R1: the count advances by one per counting edge.
    assert_step_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));
    // R2: the all-ones value wraps to zero.
    assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(cnt_o) == CNT_MAX)) |-> (cnt_o == '0));
    // R5: an edge with reset low leaves the count at zero.
    assert_reset_clear_R5: assert property (@(posedge clk)
        !rst_n |=> (cnt_o == '0));
endmodule

// File: rtl/value_decoder.sv
// Module: value_decoder
// Compares the registered count against each configured value and raises
// one match bit per value. The match bits are full-cycle levels.
// Assumes: the configured values are distinct.
module value_decoder #(
    parameter int unsigned CNT_W = 3,
    parameter int unsigned N_STB = 3,
    parameter logic [N_STB*CNT_W-1:0] MATCH_VALS = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [N_STB-1:0] match_o
);
    genvar gk;
    generate
        for (gk = 0; gk < N_STB; gk++) begin : g_cmp
            // Purpose: equality compare of the count with value gk.
            assign match_o[gk] = (cnt_i == MATCH_VALS[gk*CNT_W +: CNT_W]);
        end
    endgenerate

    // R3: distinct values never match at once.
    assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_o));
endmodule

// File: rtl/phase_gate.sv
// Module: phase_gate
// ANDs each match level with the inverted clock and with reset inactive, so
// that each strobe fills only the low half of the cycle.
// Assumes: match levels change only just after the rising edge.
module phase_gate #(
    parameter int unsigned N_STB = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_STB-1:0] match_i,
    output logic [N_STB-1:0] strobe_o
);
    logic low_phase;

    // Purpose: enable the strobes only in the clock-low phase outside reset.
    assign low_phase = ~clk & rst_n;
    // Purpose: gate every match bit with the phase enable.
    assign strobe_o  = match_i & {N_STB{low_phase}};

    // R4: just before a falling edge (the high phase), strobes are quiet.
    assert_high_quiet_R4: assert property (@(negedge clk) disable iff (!rst_n)
        strobe_o == '0);
    // R4: just before a rising edge (the low phase), strobes follow the match levels.
    assert_low_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o == match_i);
endmodule

// File: rtl/phase_strobe_counter.sv
// Module: phase_strobe_counter (top)
// Free-running toggle-cell counter whose selected values produce strobes
// that last half a cycle, in the clock-low phase.
// Assumes: synchronous active-low reset held for at least one rising edge at start-up.
module phase_strobe_counter
    import pscnt_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W,
    parameter int unsigned N_STB = DEF_N_STB,
    parameter logic [N_STB*CNT_W-1:0] MATCH_VALS = DEF_MATCH
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [N_STB-1:0] strobe_o,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] cnt;
    logic [N_STB-1:0] match;

    toggle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (cnt)
    );

    value_decoder #(.CNT_W(CNT_W), .N_STB(N_STB), .MATCH_VALS(MATCH_VALS)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_i   (cnt),
        .match_o (match)
    );

    phase_gate #(.N_STB(N_STB)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .match_i  (match),
        .strobe_o (strobe_o)
    );

    // Purpose: expose the count for observation.
    assign count_o = cnt;

    // R7: with no match, no strobe in any phase.
    assert_no_match_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match == '0) |-> (strobe_o == '0));
endmodule

// File: tb/phase_strobe_counter_tb.sv
// Bench for phase_strobe_counter: random resets plus directed walks.
module phase_strobe_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] strobe_o;
    logic [2:0] count_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    phase_strobe_counter dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_o (strobe_o),
        .count_o  (count_o)
    );

    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    function automatic logic [2:0] exp_strobe(input logic [2:0] v);
        exp_strobe = {v == 3'd5, v == 3'd3, v == 3'd2};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    logic [2:0] model = '0;
    bit model_ok = 0;

    // One cycle: drive rst_n in the low phase, then check both phases.
    task automatic run_cycle(input logic r);
        logic [2:0] prev;
        bit prev_ok;
        prev = model;
        prev_ok = model_ok;
        rst_n = r;
        @(posedge clk);
        if (!r) begin model = '0; model_ok = 1; end
        else    model = model + 3'd1;
        #1;
        // High phase: no strobe.
        check("R4 high-phase strobe", strobe_o, 0);
        if (!r) check("R5 strobe in reset", strobe_o, 0);
        @(negedge clk);
        #1;
        if (!r) begin
            check("R5 count after reset edge", count_o, 0);
            check("R5 strobe in reset low phase", strobe_o, 0);
        end else if (model_ok) begin
            if (prev_ok && prev == 3'd7) check("R2 wrap to zero", count_o, 0);
            else                         check("R1 count step", count_o, model);
            if (prev_ok) begin
                for (int i = 0; i < 3; i++) begin
                    bit lower_ones = 1;
                    for (int j = 0; j < i; j++) if (!prev[j]) lower_ones = 0;
                    check("R6 bit toggle", int'(count_o[i] != prev[i]), int'(lower_ones));
                end
            end
            if (exp_strobe(model) == 3'b000)
                check("R7 no strobe off-match", strobe_o, 0);
            else
                check("R3 decode strobe", strobe_o, exp_strobe(model));
            check("R3 at most one strobe", $countones(strobe_o) <= 1, 1);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        // Reset state.
        run_cycle(1'b0);
        run_cycle(1'b0);
        check("R5 reset state count", count_o, 0);
        // Directed: two full walks to cover every value and a wrap.
        for (int k = 0; k < 17; k++) run_cycle(1'b1);
        // Directed: reset in the middle of the sequence at count 5.
        while (count_o != 3'd5) run_cycle(1'b1);
        run_cycle(1'b0);
        check("R5 mid-count clear", count_o, 0);
        // Random: mostly counting, occasional multi-cycle resets.
        for (int k = 0; k < 3000; k++) begin
            if (($urandom % 40) == 0) begin
                int len = 1 + ($urandom % 3);
                for (int m = 0; m < len; m++) run_cycle(1'b0);
            end else begin
                run_cycle(1'b1);
            end
        end
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end
endmodule